// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Status

This block is the receive-side queue of a serial port. A character deserializer pushes each finished character into it, together with three error flags: break, framing and parity. The flags are stored in the same 11-bit entry as the byte, so they leave the queue at the same moment as the byte. A host reads the byte at the head through a simple register-style port and pops it with a read strobe.

A status view gives the host the error picture in one of two ways, chosen by a mode input. In per-character mode it shows the flags of the entry now at the head, so status must be read before the byte is popped. In block mode it shows the OR of the flags of every byte accepted since the last reset-error command, which is control code 0x04. A level-sensitive interrupt request is raised while the fill count is at or above a threshold. The threshold comes from a mode-derived input until the host writes the threshold register, and from that register after that.

The store tracks its fill with three states: FILL_EMPTY, FILL_PART and FILL_FULL. Its transitions are these. EMPTY_TO_PART happens on an accepted write. PART_TO_FULL happens on a write without a read when 255 entries are held. PART_TO_EMPTY happens on a read without a write when one entry is held. FULL_TO_PART happens on any read. The threshold source has two states, THR_FROM_MODE and THR_FROM_REG. Its single transition, MODE_TO_REG, is taken on a threshold-register write, and only reset returns the source to THR_FROM_MODE.

Top module: `rx_status_fifo`

## Requirements
- R1: Entries leave in arrival order. Entry bit 10 is break, bit 9 is framing, bit 8 is parity and bits 7:0 are data. `rd_data` shows the data of the head entry, and `rd_en` pops that entry.
- R2: Data is masked to the character length before it is stored. `char_len` 0 keeps 5 bits, 1 keeps 6 bits, 2 keeps 7 bits and 3 keeps all 8. The upper bits read back as zero.
- R3: With `err_mode`=0, `status` equals {break, framing, parity} of the head entry. It is 0 when the queue is empty.
- R4: With `err_mode`=1, `status` is the OR of the flags of all accepted bytes since reset or the last `cmd_wr` with `cmd_code`=0x04. A byte accepted in the same cycle as the clear is included. Other codes have no effect.
- R5: `count` ranges over 0 to 256. A read and a write accepted in the same cycle leave it unchanged. `full` means 256 and `empty` means 0.
- R6: A write while full is dropped and sets `overrun`. The flag stays set until reset. With full plus a read and a write in one cycle, the read happens and the write is dropped.
- R7: A read while empty leaves `count` and the pointers unchanged. `rd_data` reads 0 while empty.
- R8: `irq` is high exactly while `count` >= threshold+1, where the threshold is an 8-bit position from 0 to 255.
- R9: Before any `thr_wr`, the threshold is `mode_thr`. After a `thr_wr`, it is the last `thr_data` written, and `mode_thr` is then ignored.
- R10: After reset, `count` is 0, `empty` is 1, and `status`, `overrun` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break detected for this character |
| wr_frm | input | 1 | Framing error for this character |
| wr_par | input | 1 | Parity error for this character |
| char_len | input | 2 | Character length code (0 to 3 means 5 to 8 bits) |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Data of the head entry |
| err_mode | input | 1 | 0 = per-character status, 1 = block status |
| status | output | 3 | {break, framing, parity} view |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code (0x04 clears accumulated errors) |
| thr_wr | input | 1 | Threshold register write strobe |
| thr_data | input | 8 | Threshold register value |
| mode_thr | input | 8 | Threshold derived from mode settings |
| count | output | 9 | Fill count |
| full | output | 1 | Queue holds 256 entries |
| empty | output | 1 | Queue holds no entry |
| overrun | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Fill-level interrupt request |

## Verification
A corrupted pointer or a bad fill state shows at the ports in the same cycle. The head data, the per-character status or the count drift away from the reference queue in the bench, and `rd_data` is checked after every clock. A corrupted error accumulator shows in block mode as soon as the mode is selected. A stale threshold source shows as `irq` at the wrong fill level on the next count change. Random mixes of writes and reads across all fill levels, mode changes and clear commands are compared every cycle. The bench also drives the empty, full, overrun and same-cycle clear corners directly.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam logic [7:0] CMD_RESET_ERR = 8'h04;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_t;

    typedef enum logic {
        THR_FROM_MODE = 1'b0,
        THR_FROM_REG  = 1'b1
    } thr_src_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  rx_entry_t     wr_entry,
    input  logic          rd_en,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          wr_ok
);
    rx_entry_t   mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    fill_state_t state_q, state_d;
    logic        rd_ok;

    assign wr_ok = wr_en && (state_q != FILL_FULL);
    assign rd_ok = rd_en && (state_q != FILL_EMPTY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (wr_ok) state_d = (DEPTH == 1) ? FILL_FULL : FILL_PART;
            FILL_PART: begin
                if (wr_ok && !rd_ok && count == CW'(DEPTH - 1))
                    state_d = FILL_FULL;
                else if (rd_ok && !wr_ok && count == CW'(1))
                    state_d = FILL_EMPTY;
            end
            FILL_FULL:  if (rd_ok) state_d = FILL_PART;
            default:    state_d = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            if (wr_ok && !rd_ok)      count <= count + CW'(1);
            else if (rd_ok && !wr_ok) count <= count - CW'(1);
            if (wr_en && !wr_ok) overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_entry;
    end

    always_comb begin
        full  = (state_q == FILL_FULL);
        empty = (state_q == FILL_EMPTY);
        head  = empty ? '0 : mem[rptr];
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_hold_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> count == $past(count));
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);
    p_empty_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> count == '0);
endmodule

// File: rtl/rxf_errview.sv
module rxf_errview
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       block_mode,
    input  logic       clr,
    input  logic       wr_ok,
    input  logic [2:0] wr_flags,
    input  logic [2:0] head_flags,
    output logic [2:0] status
);
    logic [2:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clr)   acc <= wr_ok ? wr_flags : 3'b000;
        else if (wr_ok) acc <= acc | wr_flags;
    end

    always_comb begin
        status = block_mode ? acc : head_flags;
    end

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_ok) |=> acc == 3'b000);
    p_accum_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (acc & $past(acc)) == $past(acc));
endmodule

// File: rtl/rxf_level.sv
module rxf_level
    import rxf_pkg::*;
#(
    parameter int AW = 8,
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_data,
    input  logic [AW-1:0] mode_thr,
    input  logic [CW-1:0] count,
    output logic          irq
);
    thr_src_t      src_q, src_d;
    logic [AW-1:0] thr_q;
    logic [AW-1:0] thr_eff;
    logic [CW-1:0] limit;

    always_comb begin
        src_d = src_q;
        unique case (src_q)
            THR_FROM_MODE: if (thr_wr) src_d = THR_FROM_REG;
            THR_FROM_REG:  src_d = THR_FROM_REG;
            default:       src_d = THR_FROM_MODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= THR_FROM_MODE;
            thr_q <= '0;
        end else begin
            src_q <= src_d;
            if (thr_wr) thr_q <= thr_data;
        end
    end

    always_comb begin
        thr_eff = (src_q == THR_FROM_REG) ? thr_q : mode_thr;
        limit   = {1'b0, thr_eff} + CW'(1);
        irq     = (count >= limit);
    end

    p_src_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == THR_FROM_REG) |=> (src_q == THR_FROM_REG));
    p_irq_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count != '0);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_brk,
    input  logic          wr_frm,
    input  logic          wr_par,
    input  logic [1:0]    char_len,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          err_mode,
    output logic [2:0]    status,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_code,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_data,
    input  logic [AW-1:0] mode_thr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          irq
);
    rx_entry_t  in_entry, head;
    logic [7:0] len_mask;
    logic       wr_ok;
    logic       clr;

    always_comb begin
        len_mask       = 8'hFF >> (2'd3 - char_len);
        in_entry.brk   = wr_brk;
        in_entry.frm   = wr_frm;
        in_entry.par   = wr_par;
        in_entry.data  = wr_data & len_mask;
        clr            = cmd_wr && (cmd_code == CMD_RESET_ERR);
    end

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (in_entry),
        .rd_en    (rd_en),
        .head     (head),
        .count    (count),
        .full     (full),
        .empty    (empty),
        .overrun  (overrun),
        .wr_ok    (wr_ok)
    );

    rxf_errview u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (err_mode),
        .clr        (clr),
        .wr_ok      (wr_ok),
        .wr_flags   ({wr_brk, wr_frm, wr_par}),
        .head_flags ({head.brk, head.frm, head.par}),
        .status     (status)
    );

    rxf_level #(.AW(AW)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_wr   (thr_wr),
        .thr_data (thr_data),
        .mode_thr (mode_thr),
        .count    (count),
        .irq      (irq)
    );

    assign rd_data = head.data;

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty && count == '0);
    p_empty_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> rd_data == 8'h00);
    p_char_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !err_mode) |-> status == 3'b000);
endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'd3;
    logic       rd_en = 1'b0, err_mode = 1'b0, cmd_wr = 1'b0, thr_wr = 1'b0;
    logic [7:0] cmd_code = '0, thr_data = '0, mode_thr = '0;
    logic [7:0] rd_data;
    logic [2:0] status;
    logic [8:0] count;
    logic       full, empty, overrun, irq;

    always #2 clk = ~clk;

    rx_status_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .char_len(char_len),
        .rd_en(rd_en), .rd_data(rd_data), .err_mode(err_mode), .status(status),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .thr_wr(thr_wr), .thr_data(thr_data),
        .mode_thr(mode_thr), .count(count), .full(full), .empty(empty),
        .overrun(overrun), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model
    logic [10:0] q [256];
    int  mh = 0, mt = 0, mc = 0;
    logic [2:0] acc = '0;
    bit  ovr = 1'b0, src_reg = 1'b0;
    int  thr_reg = 0;

    function automatic logic [7:0] exp_data();
        return (mc > 0) ? q[mh][7:0] : 8'h00;
    endfunction
    function automatic logic [2:0] exp_status();
        if (err_mode) return acc;
        return (mc > 0) ? q[mh][10:8] : 3'b000;
    endfunction
    function automatic bit exp_irq();
        int lim;
        lim = (src_reg ? thr_reg : int'(mode_thr)) + 1;
        return mc >= lim;
    endfunction
    function automatic logic [7:0] masked(logic [7:0] d, logic [1:0] len);
        return d & 8'(('h1 << (5 + int'(len))) - 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 rd_data", int'(rd_data), int'(exp_data()));
        chk(err_mode ? "R4 block status" : "R3 char status", int'(status), int'(exp_status()));
        chk("R5 count", int'(count), mc);
        chk("R5 full", int'(full), int'(mc == 256));
        chk("R5 empty", int'(empty), int'(mc == 0));
        chk("R6 overrun", int'(overrun), int'(ovr));
        chk("R8 irq", int'(irq), int'(exp_irq()));
    endtask

    // one clock: inputs driven after negedge, model updated at posedge, outputs checked at next negedge
    task automatic cyc(bit w, logic [7:0] d, logic [2:0] fl, bit r,
                       bit cw, logic [7:0] cc, bit tw, logic [7:0] tv);
        bit wok, rok, clr;
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = fl;
        rd_en = r; cmd_wr = cw; cmd_code = cc; thr_wr = tw; thr_data = tv;
        @(posedge clk);
        wok = w && mc < 256;
        rok = r && mc > 0;
        clr = cw && cc == 8'h04;
        if (w && !wok) ovr = 1'b1;
        if (rok) mh = (mh + 1) % 256;
        if (wok) begin
            q[mt] = {fl, masked(d, char_len)};
            mt = (mt + 1) % 256;
        end
        mc = mc + int'(wok) - int'(rok);
        if (clr) acc = wok ? fl : 3'b000;
        else if (wok) acc = acc | fl;
        if (tw) begin src_reg = 1'b1; thr_reg = int'(tv); end
        @(negedge clk);
        wr_en = 0; rd_en = 0; cmd_wr = 0; thr_wr = 0;
        check_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h1D5E);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 count", int'(count), 0);
        chk("R10 empty", int'(empty), 1);
        chk("R10 status", int'(status), 0);
        chk("R10 overrun", int'(overrun), 0);
        chk("R10 irq", int'(irq), 0);

        // R1/R3 order and per-character flags
        mode_thr = 8'd200;
        cyc(1, 8'hA5, 3'b100, 0, 0, 0, 0, 0);
        cyc(1, 8'h3C, 3'b010, 0, 0, 0, 0, 0);
        cyc(1, 8'h81, 3'b001, 0, 0, 0, 0, 0);
        chk("R3 head flags", int'(status), 4);
        chk("R1 head data", int'(rd_data), 8'hA5);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R3 status after pop", int'(status), 2);
        chk("R1 second data", int'(rd_data), 8'h3C);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);

        // R2 character-length masking
        for (int l = 0; l < 4; l++) begin
            char_len = 2'(l);
            cyc(1, 8'hFF, 3'b000, 0, 0, 0, 0, 0);
        end
        char_len = 2'd3;
        chk("R2 5-bit", int'(rd_data), 8'h1F);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 6-bit", int'(rd_data), 8'h3F);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 7-bit", int'(rd_data), 8'h7F);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 8-bit", int'(rd_data), 8'hFF);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);

        // R7 read while empty
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R7 empty read count", int'(count), 0);
        chk("R7 empty read data", int'(rd_data), 0);
        cyc(1, 8'h55, 3'b000, 0, 0, 0, 0, 0);
        chk("R7 pointers kept", int'(rd_data), 8'h55);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);

        // R4 block mode accumulation and clear
        err_mode = 1'b1;
        cyc(0, 0, 0, 0, 1, 8'h04, 0, 0);
        chk("R4 cleared", int'(status), 0);
        cyc(1, 8'h01, 3'b001, 0, 0, 0, 0, 0);
        cyc(1, 8'h02, 3'b100, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 OR kept after pop", int'(status), 5);
        cyc(0, 0, 0, 0, 1, 8'h05, 0, 0);
        chk("R4 other code ignored", int'(status), 5);
        cyc(1, 8'h03, 3'b010, 0, 1, 8'h04, 0, 0);
        chk("R4 same-cycle byte counted", int'(status), 2);
        err_mode = 1'b0;
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);

        // R8/R9 threshold
        mode_thr = 8'd3;
        for (int i = 0; i < 4; i++) cyc(1, 8'(i), 3'b000, 0, 0, 0, 0, 0);
        chk("R8 irq at mode threshold", int'(irq), 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 8'd9);
        chk("R9 register overrides", int'(irq), 0);
        mode_thr = 8'd0;
        @(negedge clk);
        chk("R9 mode_thr ignored", int'(irq), 0);
        for (int i = 0; i < 6; i++) cyc(1, 8'(i), 3'b000, 0, 0, 0, 0, 0);
        chk("R8 irq at count 10", int'(irq), 1);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R8 irq drops below", int'(irq), 0);

        // R6 fill to full, overrun, full read+write
        while (mc < 256) cyc(1, 8'(mc), 3'b001, 0, 0, 0, 0, 0);
        chk("R5 full at 256", int'(full), 1);
        cyc(1, 8'hEE, 3'b111, 0, 0, 0, 0, 0);
        chk("R6 overrun set", int'(overrun), 1);
        chk("R6 count held", int'(count), 256);
        cyc(1, 8'hEE, 3'b111, 1, 0, 0, 0, 0);
        chk("R6 full rd+wr drops write", int'(count), 255);
        cyc(1, 8'h77, 3'b000, 1, 0, 0, 0, 0);
        chk("R5 rd+wr count unchanged", int'(count), 255);

        // random mix
        for (int n = 0; n < 6000; n++) begin
            int pw;
            bit w, r, cw, tw;
            pw = (n / 1500) % 2 == 0 ? 60 : 40;
            w  = ($urandom % 100) < pw;
            r  = ($urandom % 100) < (100 - pw);
            cw = ($urandom % 16) == 0;
            tw = ($urandom % 200) == 0;
            if (($urandom % 50) == 0) err_mode = ~err_mode;
            if (($urandom % 100) == 0) mode_thr = 8'($urandom);
            if (($urandom % 30) == 0) char_len = 2'($urandom);
            cyc(w, 8'($urandom), 3'($urandom), r, cw,
                (($urandom % 2) == 0) ? 8'h04 : 8'($urandom), tw, 8'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule